// File: doc/BRIEF.md
# DMA Channel Interrupt Status and Completion Accounting

This block collects the event strobes of one DMA channel engine into a 12-bit pending-interrupt status register. It combines that register with a mask to drive one level-sensitive interrupt line. Each event sets a sticky status bit. Software clears status bits by writing ones to them. The mask cannot be written directly. Software changes it through two write-only ports: one unmasks bits and the other masks them.

Two 8-bit counters record completed source and destination descriptors. Reading a counter clears it. If a counter wraps, a dedicated accounting-error status bit is raised. Any bus access to an offset outside the six defined registers raises an invalid-access status bit.

The register bus is a simple single-cycle request interface. Read data is combinational from the current state. Every write, clear-on-read and event takes effect at the clock edge that ends the access cycle.

Top module: `dma_irq_ctrl`

## Requirements
- R1: Status bit positions: 0 invalid access, 1 source descriptor done, 2 destination descriptor done, 3 byte-count overflow, 4 source accounting wrap, 5 destination accounting wrap, 6 source-descriptor read error, 7 destination-descriptor read error, 8 data read error, 9 data write error, 10 transfer done, 11 pause. Status resets to 0, an event sets its bit, and bits 31..12 read 0.
- R2: A write to the status offset 0x00 clears each status bit whose written bit is 1 and leaves the others unchanged.
- R3: The mask (offset 0x04) resets to 0xFFF. Bus writes to it are ignored.
- R4: A write to the unmask offset 0x08 clears the mask bits set in the written data. A write to the mask-set offset 0x0C sets them. Both offsets read as 0.
- R5: irq_o is high exactly when some status bit is 1 while its mask bit is 0. It reflects a change from the cycle after that change.
- R6: Each source-done (descriptor-completion) strobe increments the source counter (offset 0x10). Each destination-done strobe increments the destination counter (offset 0x14). Reading a counter returns its value and clears it. Writes to the counter offsets are ignored.
- R7: An increment of a counter holding 255 wraps it to 0 and sets its accounting-wrap status bit (4 or 5) together with its done bit.
- R8: A read or write to any offset other than 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14 sets status bit 0. Such a read returns 0, and such a write changes nothing else.
- R9: When an event sets a status bit in the same cycle that a write clears it, the bit ends up set.
- R10: When a counter read and an increment of that counter fall in the same cycle, the read returns the old value and the counter then holds 1. No wrap is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access request, one cycle per access |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid during a read request |
| src_done_i | input | 1 | Source descriptor completed |
| dst_done_i | input | 1 | Destination descriptor completed |
| byte_ovf_i | input | 1 | Byte count overflow |
| axi_err_i | input | 4 | Read error on source descriptor, destination descriptor, data read, data write (bits 0..3) |
| xfer_done_i | input | 1 | Transfer complete |
| pause_i | input | 1 | Channel paused |
| irq_o | output | 1 | Level interrupt |

## Verification
Read data is due in the same cycle as the read request. The bench therefore samples rdata_o 1 ns after driving the request at the falling edge. Status, mask, counter and irq_o results are due one cycle after the stimulus. Each bench task drives at a falling edge and returns at the next falling edge, after the state-changing rising edge, so every check reads state that is already settled. Simultaneous cases (set against clear, increment against clear-on-read) are created by driving both stimuli in the same falling-edge window.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int NUM_IRQ = 12;

  localparam int BIT_INV      = 0;
  localparam int BIT_SRC_DONE = 1;
  localparam int BIT_DST_DONE = 2;
  localparam int BIT_BYTE_OVF = 3;
  localparam int BIT_SRC_WRAP = 4;
  localparam int BIT_DST_WRAP = 5;
  localparam int BIT_AXI_LO   = 6;
  localparam int BIT_XFER     = 10;
  localparam int BIT_PAUSE    = 11;

  localparam int OFF_STATUS = 'h00;
  localparam int OFF_MASK   = 'h04;
  localparam int OFF_UNMASK = 'h08;
  localparam int OFF_DOMASK = 'h0C;
  localparam int OFF_CNT0   = 'h10;
  localparam int OFF_CNT1   = 'h14;

  localparam int NUM_CNT = 2;
endpackage

// File: rtl/dma_irq_acct.sv
module dma_irq_acct #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  // clear has priority as a base: a simultaneous increment lands on zero
  assign wrap_o = inc_i & ~clr_i & (&cnt_q);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= inc_i ? CNT_W'(1) : '0;
    else if (inc_i)  cnt_q <= cnt_q + CNT_W'(1);
  end

  AST_CNT_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i) |=> cnt_q == $past(cnt_q) + CNT_W'(1)); // R6
  AST_CNT_COR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !inc_i) |=> cnt_q == '0); // R6
  AST_COR_INC_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && inc_i) |=> cnt_q == CNT_W'(1)); // R10
  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> cnt_q == '0); // R7
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status #(
  parameter int N = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] w1c_i,
  input  logic [N-1:0] unmask_i,
  input  logic [N-1:0] domask_i,
  output logic [N-1:0] status_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] status_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      mask_q   <= '1;
    end else begin
      status_q <= (status_q & ~w1c_i) | set_i;
      mask_q   <= (mask_q & ~unmask_i) | domask_i;
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = |(status_q & ~mask_q);

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> (status_q & $past(set_i)) == $past(set_i)); // R9
  AST_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(w1c_i & ~set_i)) |=> (status_q & $past(w1c_i & ~set_i)) == '0); // R2
  AST_UNMASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|unmask_i) && !(|domask_i)) |=> (mask_q & $past(unmask_i)) == '0); // R4
  AST_DOMASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|domask_i) |=> (mask_q & $past(domask_i)) == $past(domask_i)); // R4
  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_q) |-> !irq_o); // R5
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              src_done_i,
  input  logic              dst_done_i,
  input  logic              byte_ovf_i,
  input  logic [3:0]        axi_err_i,
  input  logic              xfer_done_i,
  input  logic              pause_i,
  output logic              irq_o
);
  localparam int PAD_S = DATA_W - NUM_IRQ;
  localparam int PAD_C = DATA_W - CNT_W;

  logic rd, wr;
  logic hit_stat, hit_mask, hit_unm, hit_dom, mapped;
  logic [NUM_CNT-1:0] hit_cnt, cnt_inc, cnt_clr, cnt_wrap;
  logic [CNT_W-1:0]   cnt [NUM_CNT];
  logic [NUM_IRQ-1:0] wbits, set_vec, w1c, unm, dom, status, mask;

  assign rd = req_i & ~we_i;
  assign wr = req_i & we_i;

  assign hit_stat   = addr_i == ADDR_W'(OFF_STATUS);
  assign hit_mask   = addr_i == ADDR_W'(OFF_MASK);
  assign hit_unm    = addr_i == ADDR_W'(OFF_UNMASK);
  assign hit_dom    = addr_i == ADDR_W'(OFF_DOMASK);
  assign hit_cnt[0] = addr_i == ADDR_W'(OFF_CNT0);
  assign hit_cnt[1] = addr_i == ADDR_W'(OFF_CNT1);
  assign mapped     = hit_stat | hit_mask | hit_unm | hit_dom | (|hit_cnt);

  assign wbits = wdata_i[NUM_IRQ-1:0];
  assign w1c   = (wr && hit_stat) ? wbits : '0;
  assign unm   = (wr && hit_unm)  ? wbits : '0;
  assign dom   = (wr && hit_dom)  ? wbits : '0;

  assign cnt_inc = {dst_done_i, src_done_i};

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_acct
    assign cnt_clr[g] = rd & hit_cnt[g];
    dma_irq_acct #(.CNT_W(CNT_W)) u_acct (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (cnt_inc[g]),
      .clr_i  (cnt_clr[g]),
      .cnt_o  (cnt[g]),
      .wrap_o (cnt_wrap[g])
    );
  end

  always_comb begin
    set_vec                         = '0;
    set_vec[BIT_INV]                = req_i & ~mapped;
    set_vec[BIT_SRC_DONE]           = src_done_i;
    set_vec[BIT_DST_DONE]           = dst_done_i;
    set_vec[BIT_BYTE_OVF]           = byte_ovf_i;
    set_vec[BIT_SRC_WRAP]           = cnt_wrap[0];
    set_vec[BIT_DST_WRAP]           = cnt_wrap[1];
    set_vec[BIT_AXI_LO +: 4]        = axi_err_i;
    set_vec[BIT_XFER]               = xfer_done_i;
    set_vec[BIT_PAUSE]              = pause_i;
  end

  dma_irq_status #(.N(NUM_IRQ)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_vec),
    .w1c_i    (w1c),
    .unmask_i (unm),
    .domask_i (dom),
    .status_o (status),
    .mask_o   (mask),
    .irq_o    (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      if (hit_stat)        rdata_o = {{PAD_S{1'b0}}, status};
      else if (hit_mask)   rdata_o = {{PAD_S{1'b0}}, mask};
      else if (hit_cnt[0]) rdata_o = {{PAD_C{1'b0}}, cnt[0]};
      else if (hit_cnt[1]) rdata_o = {{PAD_C{1'b0}}, cnt[1]};
    end
  end

  AST_INV_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !mapped) |=> status[BIT_INV]); // R8
  AST_INV_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && !mapped) |-> rdata_o == '0); // R8
  AST_MASK_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && hit_mask) |=> $stable(mask)); // R3
  AST_WRAP_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wrap[0] |=> status[BIT_SRC_WRAP] && status[BIT_SRC_DONE]); // R7
endmodule

// File: tb/dma_irq_ctrl_bench.sv
module dma_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [11:0] ev = '0;
  logic        irq;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dma_irq_ctrl u_dma_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata),
    .src_done_i(ev[1]), .dst_done_i(ev[2]), .byte_ovf_i(ev[3]),
    .axi_err_i(ev[9:6]), .xfer_done_i(ev[10]), .pause_i(ev[11]),
    .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0; ev = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    req = 1; we = 0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    req = 0; ev = '0;
  endtask

  task automatic pulse(input logic [11:0] v);
    ev = v;
    @(negedge clk);
    ev = '0;
  endtask

  logic [31:0] d;

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // reset state
    rd('h00, d); chk("R1 status reset", d, 0);
    rd('h04, d); chk("R3 mask reset", d, 'hFFF);
    chk("R5 irq reset", irq, 0);
    rd('h10, d); chk("R6 src count reset", d, 0);
    rd('h14, d); chk("R6 dst count reset", d, 0);

    // per-event sweep
    foreach (ev[k]) begin
      if (k == 0 || k == 4 || k == 5) continue;
      pulse(12'(1) << k);
      rd('h00, d); chk($sformatf("R1 bit %0d set", k), d, 32'(1) << k);
      chk("R5 masked irq low", irq, 0);
      wr('h08, 32'(1) << k);
      chk("R5 unmasked irq high", irq, 1);
      rd('h04, d); chk("R4 unmask", d, 'hFFF & ~(32'(1) << k));
      wr('h0C, 32'(1) << k);
      chk("R5 remasked irq low", irq, 0);
      rd('h04, d); chk("R4 remask", d, 'hFFF);
      wr('h00, 32'(1) << k);
      rd('h00, d); chk("R2 w1c clears", d, 0);
    end
    rd('h10, d); chk("R6 src count after sweep", d, 1);
    rd('h14, d); chk("R6 dst count after sweep", d, 1);
    rd('h10, d); chk("R6 src cleared on read", d, 0);

    // W1C leaves other bits
    pulse(12'hC00);
    wr('h00, 'h400);
    rd('h00, d); chk("R2 partial w1c", d, 'h800);
    wr('h00, 'hFFF);

    // read-only mask, write-only ports read zero, reserved bits
    wr('h04, 0);
    rd('h04, d); chk("R3 mask write ignored", d, 'hFFF);
    rd('h08, d); chk("R4 unmask reads zero", d, 0);
    rd('h0C, d); chk("R4 mask-set reads zero", d, 0);
    wr('h08, 'hFFFF_FFFF);
    rd('h04, d); chk("R4 unmask all", d, 0);
    pulse(12'hFCE);
    rd('h00, d); chk("R1 upper bits zero", d, 'hFCE);
    wr('h00, 'hFFFF_FFFF);
    rd('h00, d); chk("R2 clear all", d, 0);
    chk("R5 irq low when clear", irq, 0);
    rd('h10, d); rd('h14, d);

    // counter reach 255 without wrap, then wrap
    for (int i = 0; i < 255; i++) pulse(12'h002);
    rd('h00, d); chk("R7 no wrap at 255", d, 'h002);
    rd('h10, d); chk("R6 src count 255", d, 255);
    rd('h10, d); chk("R6 src count cleared", d, 0);
    wr('h00, 'hFFF);
    for (int i = 0; i < 256; i++) pulse(12'h002);
    rd('h00, d); chk("R7 src wrap bit", d, 'h012);
    rd('h10, d); chk("R7 src count wrapped", d, 0);
    chk("R5 irq on wrap", irq, 1);
    wr('h00, 'hFFF);
    for (int i = 0; i < 256; i++) pulse(12'h004);
    rd('h00, d); chk("R7 dst wrap bit", d, 'h024);
    rd('h14, d); chk("R7 dst count wrapped", d, 0);
    wr('h00, 'hFFF);

    // counter offsets read-only
    pulse(12'h002);
    wr('h10, 'h55);
    rd('h10, d); chk("R6 count write ignored", d, 1);
    rd('h00, d); chk("R8 mapped write no flag", d, 'h002);
    wr('h00, 'hFFF);

    // invalid access
    rd('h18, d); chk("R8 unmapped read zero", d, 0);
    rd('h00, d); chk("R8 unmapped read flags", d, 'h001);
    chk("R5 irq on invalid", irq, 1);
    wr('h00, 'hFFF);
    wr('h40, 'hFFF);
    rd('h00, d); chk("R8 unmapped write flags", d, 'h001);
    rd('h04, d); chk("R8 unmapped write no effect", d, 0);
    wr('h00, 'hFFF);
    rd('h01, d); chk("R8 misaligned read zero", d, 0);
    rd('h00, d); chk("R8 misaligned flags", d, 'h001);
    wr('h00, 'hFFF);

    // set wins over clear
    pulse(12'h400);
    ev = 12'h400;
    wr('h00, 'h400);
    rd('h00, d); chk("R9 set wins", d, 'h400);
    wr('h00, 'hFFF);

    // clear-on-read with increment
    for (int i = 0; i < 3; i++) pulse(12'h002);
    ev = 12'h002;
    rd('h10, d); chk("R10 read old value", d, 3);
    rd('h10, d); chk("R10 count holds one", d, 1);
    rd('h00, d); chk("R10 no wrap flag", d, 'h002);
    wr('h00, 'hFFF);
    rd('h10, d);

    // irq versus single unmasked bit
    pulse(12'hFCE);
    for (int j = 0; j < 12; j++) begin
      wr('h0C, 'hFFF);
      wr('h08, 32'(1) << j);
      chk($sformatf("R5 irq single unmask %0d", j), irq, (12'hFCE >> j) & 1);
    end
    wr('h00, 'hFFF);
    chk("R5 irq drops after clear", irq, 0);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule